// File: doc/BRIEF.md
# Dual-Clock FIFO with Two Output Protocols

This block is an 18-bit first-in first-out store. It has one clock for writes and an independent clock for reads. Writes are accepted on the write clock whenever the active-low write enable is low and free space remains.

A static mode input chooses how the read side behaves:
- In request mode, each word, including the first, is moved into the registered output only when the active-low read enable asks for it. A full indicator and an empty indicator, both active low, tell the producer and the consumer when to stop.
- In fall-through mode, the oldest stored word moves into the output register by itself. Read enable only consumes the word being shown. The two indicators become active-high "blocked" signals: an input-ready that rises to block writes and an output-ready that is high while no word is on the output.

Three level flags report fill against fixed and programmable thresholds: half-full, almost-full and almost-empty. The two programmable thresholds are inputs. Pointers cross between clock domains as Gray code through two-flop synchronizers. Each flag is produced by registers clocked in the domain that owns it. The fill level counts words held in storage. In fall-through mode, a word that has already moved into the output register is not counted.

Top module: `dualmode_fifo`

## Requirements
- R1: While rstN is low and after its release with no traffic: rdData is 0, halfFullN and almostFullN are 1, almostEmptyN is 0. In request mode fullOrIr is 1 and emptyOrOr is 0. In fall-through mode fullOrIr is 0 and emptyOrOr is 1.
- R2: A rising wrClk edge stores wrData when wrEnN is 0 and the store is not full. When the store is full, a write attempt is dropped and changes no stored word and no pointer.
- R3: The store holds DEPTH words. When it is full, fullOrIr is 0 in request mode and 1 in fall-through mode. It returns to its not-full value a few wrClk cycles after a read frees a location.
- R4: In request mode, a rising rdClk edge with rdEnN at 0 and the store not empty loads the oldest word into rdData. When rdEnN is 1, rdData holds.
- R5: In request mode, emptyOrOr is 0 while the store is empty, and rdEnN then leaves rdData unchanged. emptyOrOr rises after a write once the write pointer has crossed into the read domain. The first word still needs a request.
- R6: In fall-through mode, a word written into an empty block appears on rdData, with emptyOrOr going low, on the third rising rdClk edge after the writing wrClk edge, without rdEnN.
- R7: In fall-through mode, a shown word stays on rdData while rdEnN is 1. A read of the last word sets emptyOrOr to 1. rdEnN has no effect while emptyOrOr is 1.
- R8: halfFullN is 0 when the stored count exceeds DEPTH/2 and 1 otherwise.
- R9: almostFullN is 0 when DEPTH minus the stored count is at or below fullOfs.
- R10: almostEmptyN is 0 when the stored count is at or below emptyOfs.
- R11: Words leave in the order they were accepted, with none lost or duplicated, under concurrent reads and writes with gaps on either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock, asynchronous to wrClk |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| fwftMode | input | 1 | 0 = request mode, 1 = fall-through mode; change only during reset |
| wrData | input | DATA_W (18) | Write data |
| wrEnN | input | 1 | Active-low write enable |
| rdEnN | input | 1 | Active-low read enable |
| emptyOfs | input | ADDR_W+1 | Almost-empty threshold in words |
| fullOfs | input | ADDR_W+1 | Almost-full threshold in free words |
| rdData | output | DATA_W (18) | Registered read data |
| fullOrIr | output | 1 | Full (active low, request mode) or input-ready (high blocks writes, fall-through mode) |
| emptyOrOr | output | 1 | Empty (active low, request mode) or output-ready (high when no word shown, fall-through mode) |
| halfFullN | output | 1 | Low when more than half full |
| almostFullN | output | 1 | Low when free space is at or below fullOfs |
| almostEmptyN | output | 1 | Low when the count is at or below emptyOfs |

## Verification
The cycle-by-cycle properties are checked on every edge:
- a write attempt while full leaves the write address unchanged;
- in request mode, the output register moves neither when idle nor when empty;
- in fall-through mode, a shown word stays on the output until it is consumed;
- full always implies half-full.

Some behaviours depend on sequences that only the bench scenarios show:
- the exact three-edge fall-through latency;
- the thresholds at which each level flag switches;
- the dropped word at full;
- end-to-end ordering under concurrent traffic in both modes.

// File: rtl/dfifo_pkg.sv
`timescale 1ns/1ps
package dfifo_pkg;

  typedef enum logic {
    MODE_REQ  = 1'b0,
    MODE_FWFT = 1'b1
  } fifoMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrStb;   // write-domain: store wrData at wrAddr
    logic rdLoad;  // read-domain: load word at rdAddr into output register
  } fifoStb_t;

endpackage

// File: rtl/dfifo_sync.sv
`timescale 1ns/1ps
module dfifo_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dfifo_ctrl.sv
`timescale 1ns/1ps
module dfifo_ctrl
  import dfifo_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifoMode_t         mode,
  input  logic              wrEnN,
  input  logic              rdEnN,
  input  logic [ADDR_W:0]   emptyOfs,
  input  logic [ADDR_W:0]   fullOfs,
  output fifoStb_t          stb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              ramFull,
  output logic              ramEmpty,
  output logic              outValid,
  output logic              halfFullN,
  output logic              almostFullN,
  output logic              almostEmptyN
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] HALF_P  = PTR_W'(DEPTH / 2);

  function automatic logic [PTR_W-1:0] binToGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] grayToBin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] wrBin, wrGray, wrBinNext, rdGraySync, rdBinSync;
  logic [PTR_W-1:0] wrLevel, wrFree;
  logic [PTR_W-1:0] rdBin, rdGray, rdBinNext, wrGraySync, wrBinSync;
  logic [PTR_W-1:0] rdLevel;
  logic             wrStb, rdLoad, outValidNext;

  // ---------------- pointer crossings ----------------
  dfifo_sync #(.W(PTR_W)) u_rdToWr (
    .clk(wrClk), .rstN(rstN), .d(rdGray), .q(rdGraySync)
  );
  dfifo_sync #(.W(PTR_W)) u_wrToRd (
    .clk(rdClk), .rstN(rstN), .d(wrGray), .q(wrGraySync)
  );

  // ---------------- write domain ----------------
  assign rdBinSync = grayToBin(rdGraySync);
  assign ramFull   = (wrGray == {~rdGraySync[PTR_W-1:PTR_W-2], rdGraySync[PTR_W-3:0]});
  assign wrStb     = !wrEnN && !ramFull;
  assign wrBinNext = wrBin + PTR_W'(wrStb);
  assign wrLevel   = wrBin - rdBinSync;
  assign wrFree    = DEPTH_P - wrLevel;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin       <= '0;
      wrGray      <= '0;
      halfFullN   <= 1'b1;
      almostFullN <= 1'b1;
    end else begin
      wrBin       <= wrBinNext;
      wrGray      <= binToGray(wrBinNext);
      halfFullN   <= !(wrLevel > HALF_P);
      almostFullN <= !(wrFree <= fullOfs);
    end
  end

  // ---------------- read domain ----------------
  assign wrBinSync = grayToBin(wrGraySync);
  assign ramEmpty  = (rdGray == wrGraySync);
  assign rdLevel   = wrBinSync - rdBin;

  always_comb begin
    if (mode == MODE_FWFT) begin
      rdLoad = !ramEmpty && (!outValid || !rdEnN);
      if (rdLoad)                    outValidNext = 1'b1;
      else if (!rdEnN)               outValidNext = 1'b0;
      else                           outValidNext = outValid;
    end else begin
      rdLoad       = !ramEmpty && !rdEnN;
      outValidNext = 1'b0;
    end
  end

  assign rdBinNext = rdBin + PTR_W'(rdLoad);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin        <= '0;
      rdGray       <= '0;
      outValid     <= 1'b0;
      almostEmptyN <= 1'b0;
    end else begin
      rdBin        <= rdBinNext;
      rdGray       <= binToGray(rdBinNext);
      outValid     <= outValidNext;
      almostEmptyN <= !(rdLevel <= emptyOfs);
    end
  end

  assign stb.wrStb  = wrStb;
  assign stb.rdLoad = rdLoad;
  assign wrAddr     = wrBin[ADDR_W-1:0];
  assign rdAddr     = rdBin[ADDR_W-1:0];
endmodule

// File: rtl/dfifo_datapath.sv
`timescale 1ns/1ps
module dfifo_datapath
  import dfifo_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifoStb_t          stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (stb.wrStb) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)           rdData <= '0;
    else if (stb.rdLoad) rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/dualmode_fifo.sv
`timescale 1ns/1ps
module dualmode_fifo
  import dfifo_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              fwftMode,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEnN,
  input  logic              rdEnN,
  input  logic [ADDR_W:0]   emptyOfs,
  input  logic [ADDR_W:0]   fullOfs,
  output logic [DATA_W-1:0] rdData,
  output logic              fullOrIr,
  output logic              emptyOrOr,
  output logic              halfFullN,
  output logic              almostFullN,
  output logic              almostEmptyN
);
  fifoMode_t         mode;
  fifoStb_t          stb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic              ramFull, ramEmpty, outValid;

  assign mode = fifoMode_t'(fwftMode);

  dfifo_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .mode(mode),
    .wrEnN(wrEnN), .rdEnN(rdEnN), .emptyOfs(emptyOfs), .fullOfs(fullOfs),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .ramFull(ramFull), .ramEmpty(ramEmpty), .outValid(outValid),
    .halfFullN(halfFullN), .almostFullN(almostFullN), .almostEmptyN(almostEmptyN)
  );

  dfifo_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .stb(stb),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  // request mode: active-low indicators; fall-through mode: active-high blockers
  assign fullOrIr  = (mode == MODE_FWFT) ? ramFull   : !ramFull;
  assign emptyOrOr = (mode == MODE_FWFT) ? !outValid : !ramEmpty;
endmodule

// File: rtl/dualmode_fifo_chk.sv
`timescale 1ns/1ps
module dualmode_fifo_chk #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              fwftMode,
  input logic              wrEnN,
  input logic              rdEnN,
  input logic [DATA_W-1:0] rdData,
  input logic              fullOrIr,
  input logic              emptyOrOr,
  input logic              halfFullN,
  input logic [ADDR_W-1:0] wrAddr
);
  logic isFull;
  assign isFull = fwftMode ? fullOrIr : !fullOrIr;

  // R2: a write attempt while full does not advance the write address
  a_r2_no_write_when_full: assert property (@(posedge wrClk) disable iff (!rstN)
    (isFull && !wrEnN) |=> $stable(wrAddr));

  // R3: a full store is always above half
  a_r3_full_over_half: assert property (@(posedge wrClk) disable iff (!rstN)
    isFull |-> !halfFullN);

  // R4: request mode, no request keeps the output
  a_r4_hold_when_idle: assert property (@(posedge rdClk) disable iff (!rstN)
    (!fwftMode && rdEnN) |=> $stable(rdData));

  // R5: request mode, read while empty leaves the output
  a_r5_empty_blocks_read: assert property (@(posedge rdClk) disable iff (!rstN)
    (!fwftMode && !emptyOrOr) |=> $stable(rdData));

  // R7: fall-through mode, a shown word persists until consumed
  a_r7_shown_word_held: assert property (@(posedge rdClk) disable iff (!rstN)
    (fwftMode && !emptyOrOr && rdEnN) |=> (!emptyOrOr && $stable(rdData)));
endmodule

bind dualmode_fifo dualmode_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .fwftMode(fwftMode),
  .wrEnN(wrEnN), .rdEnN(rdEnN), .rdData(rdData), .fullOrIr(fullOrIr),
  .emptyOrOr(emptyOrOr), .halfFullN(halfFullN), .wrAddr(wrAddr)
);

// File: tb/dualmode_fifo_tb.sv
`timescale 1ns/1ps
module dualmode_fifo_tb;
  localparam int DATA_W = 18;
  localparam int ADDR_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              wrClk = 0, rdClk = 0, rstN = 0, fwftMode = 0;
  logic [DATA_W-1:0] wrData = '0;
  logic              wrEnN = 1, rdEnN = 1;
  logic [ADDR_W:0]   emptyOfs = 4, fullOfs = 5;
  logic [DATA_W-1:0] rdData;
  logic              fullOrIr, emptyOrOr, halfFullN, almostFullN, almostEmptyN;

  dualmode_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .fwftMode(fwftMode),
    .wrData(wrData), .wrEnN(wrEnN), .rdEnN(rdEnN),
    .emptyOfs(emptyOfs), .fullOfs(fullOfs), .rdData(rdData),
    .fullOrIr(fullOrIr), .emptyOrOr(emptyOrOr), .halfFullN(halfFullN),
    .almostFullN(almostFullN), .almostEmptyN(almostEmptyN)
  );

  always #2 wrClk = ~wrClk;            // 250 MHz write clock
  initial begin
    #1.5;
    forever begin rdClk = 1; #3; rdClk = 0; #3; end
  end

  int checks = 0, failures = 0, rxCount = 0;
  logic [DATA_W-1:0] expQ[$];
  logic takePending = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // monitor / scoreboard
  always begin
    @(negedge rdClk); #1;
    if (!rstN) begin
      takePending = 0;
    end else if (fwftMode) begin
      if (!emptyOrOr) begin
        if (expQ.size() == 0) check(0, "R7", "word shown with empty queue", rdData, 0);
        else begin
          check(rdData == expQ[0], "R11", "fall-through order", rdData, expQ[0]);
          if (!rdEnN) begin void'(expQ.pop_front()); rxCount++; end
        end
      end
    end else begin
      if (takePending) begin
        if (expQ.size() == 0) check(0, "R4", "read with empty queue", rdData, 0);
        else begin
          check(rdData == expQ[0], "R4", "request-mode read data", rdData, expQ[0]);
          void'(expQ.pop_front());
        end
      end
      takePending = !rdEnN && emptyOrOr;
      if (takePending) rxCount++;
    end
  end

  task automatic pushWord(input logic [DATA_W-1:0] d, input bit acc);
    @(negedge wrClk);
    wrData = d; wrEnN = 0;
    if (acc) expQ.push_back(d);
  endtask

  task automatic idleWr();
    @(negedge wrClk); wrEnN = 1;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge rdClk);
    #1;
  endtask

  task automatic readBurst(input int n, input bit gappy);
    int target = rxCount + n;
    int cyc = 0;
    forever begin
      @(negedge rdClk);
      if (rxCount >= target) break;
      rdEnN = gappy ? ((cyc % 3) == 1) : 1'b0;
      cyc++;
    end
    rdEnN = 1;
  endtask

  task automatic doReset(input logic m);
    rstN = 0; fwftMode = m; wrEnN = 1; rdEnN = 1;
    expQ.delete();
    repeat (3) @(negedge wrClk);
    check(rdData == 0, "R1", "rdData in reset", rdData, 0);
    rstN = 1;
    settle(2);
    check(fullOrIr == !m, "R1", "full indicator after reset", fullOrIr, !m);
    check(emptyOrOr == m, "R1", "empty indicator after reset", emptyOrOr, m);
    check(halfFullN == 1, "R1", "halfFullN after reset", halfFullN, 1);
    check(almostFullN == 1, "R1", "almostFullN after reset", almostFullN, 1);
    check(almostEmptyN == 0, "R1", "almostEmptyN after reset", almostEmptyN, 0);
    check(rdData == 0, "R1", "rdData after reset", rdData, 0);
  endtask

  initial begin
    #800000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // ---------- request mode ----------
    doReset(0);

    // R5: reads while empty are ignored
    @(negedge rdClk); rdEnN = 0;
    settle(4);
    rdEnN = 1;
    check(rdData == 0, "R5", "rdData after read while empty", rdData, 0);
    check(emptyOrOr == 0, "R5", "empty stays active", emptyOrOr, 0);

    // R4/R5: first word needs a request, then holds
    pushWord(18'h1A5A5, 1); idleWr();
    settle(5);
    check(emptyOrOr == 1, "R5", "empty released after write", emptyOrOr, 1);
    check(rdData == 0, "R5", "first word not shown without request", rdData, 0);
    readBurst(1, 0);
    settle(3);
    check(rdData == 18'h1A5A5, "R4", "word held with no request", rdData, 18'h1A5A5);
    check(emptyOrOr == 0, "R5", "empty after last read", emptyOrOr, 0);

    // R8/R9/R10/R3/R2: level thresholds and full
    for (int i = 0; i < 4; i++) pushWord(DATA_W'(i * 7 + 3), 1);
    idleWr(); settle(8);
    check(almostEmptyN == 0, "R10", "count 4 at emptyOfs", almostEmptyN, 0);
    pushWord(DATA_W'(100), 1); idleWr(); settle(8);
    check(almostEmptyN == 1, "R10", "count 5 above emptyOfs", almostEmptyN, 1);
    for (int i = 5; i < DEPTH / 2; i++) pushWord(DATA_W'(i * 7 + 3), 1);
    idleWr(); settle(8);
    check(halfFullN == 1, "R8", "count at half", halfFullN, 1);
    check(almostFullN == 1, "R9", "count at half, almostFull", almostFullN, 1);
    pushWord(DATA_W'(18'h2AAAA), 1); idleWr(); settle(8);
    check(halfFullN == 0, "R8", "count half+1", halfFullN, 0);
    for (int i = DEPTH / 2 + 1; i < DEPTH - 6; i++) pushWord(DATA_W'(i * 11), 1);
    idleWr(); settle(8);
    check(almostFullN == 1, "R9", "free 6 above fullOfs", almostFullN, 1);
    pushWord(DATA_W'(18'h15555), 1); idleWr(); settle(8);
    check(almostFullN == 0, "R9", "free 5 at fullOfs", almostFullN, 0);
    for (int i = DEPTH - 5; i < DEPTH; i++) pushWord(DATA_W'(i * 13), 1);
    idleWr(); settle(8);
    check(fullOrIr == 0, "R3", "full active low in request mode", fullOrIr, 0);
    pushWord(18'h3FFFF, 0); idleWr(); settle(4);
    readBurst(1, 0);
    settle(8);
    check(fullOrIr == 1, "R3", "full released after read", fullOrIr, 1);
    readBurst(DEPTH - 1, 0);
    settle(4);
    check(emptyOrOr == 0, "R2", "dropped word not stored", emptyOrOr, 0);
    check(expQ.size() == 0, "R2", "queue drained", expQ.size(), 0);

    // R11: concurrent traffic, request mode
    fork
      begin
        for (int i = 0; i < 60; i++) begin
          pushWord(DATA_W'(18'h30000 + i * 5), 1);
          if (i % 4 == 3) idleWr();
        end
        idleWr();
      end
      readBurst(60, 1);
    join
    settle(6);
    check(expQ.size() == 0, "R11", "request mode concurrent drain", expQ.size(), 0);

    // ---------- fall-through mode ----------
    doReset(1);

    // R7: reads ignored while no word shown
    @(negedge rdClk); rdEnN = 0;
    settle(3);
    rdEnN = 1;
    check(emptyOrOr == 1, "R7", "output-ready stays high", emptyOrOr, 1);
    check(rdData == 0, "R7", "rdData unchanged", rdData, 0);

    // R6: third read edge after the write
    @(negedge wrClk);
    wrData = 18'h2C3C3; wrEnN = 0; expQ.push_back(18'h2C3C3);
    @(posedge wrClk);
    fork begin @(negedge wrClk); wrEnN = 1; end join_none
    @(posedge rdClk); @(posedge rdClk); #1;
    check(emptyOrOr == 1, "R6", "not shown after second edge", emptyOrOr, 1);
    @(posedge rdClk); #1;
    check(emptyOrOr == 0, "R6", "shown on third edge", emptyOrOr, 0);
    check(rdData == 18'h2C3C3, "R6", "fall-through data", rdData, 18'h2C3C3);
    settle(3);
    check(rdData == 18'h2C3C3 && emptyOrOr == 0, "R7", "word held", rdData, 18'h2C3C3);
    @(negedge rdClk); rdEnN = 0;
    @(negedge rdClk); rdEnN = 1; #1;
    check(emptyOrOr == 1, "R7", "output-ready high after last read", emptyOrOr, 1);

    // R11: concurrent traffic, fall-through mode
    fork
      begin
        for (int i = 0; i < 60; i++) begin
          pushWord(DATA_W'(18'h01000 + i * 9), 1);
          if (i % 5 == 2) idleWr();
        end
        idleWr();
      end
      readBurst(60, 1);
    join
    settle(6);
    check(expQ.size() == 0, "R11", "fall-through concurrent drain", expQ.size(), 0);
    check(emptyOrOr == 1, "R7", "output-ready after drain", emptyOrOr, 1);

    // R3/R2: fall-through full (storage plus the shown word)
    for (int i = 0; i < DEPTH + 1; i++) pushWord(DATA_W'(i * 3 + 1), 1);
    idleWr(); settle(8);
    check(fullOrIr == 1, "R3", "input-ready high when full", fullOrIr, 1);
    pushWord(18'h3ABCD, 0); idleWr(); settle(4);
    readBurst(DEPTH + 1, 0);
    settle(6);
    check(emptyOrOr == 1, "R2", "dropped word never shown", emptyOrOr, 1);
    check(expQ.size() == 0, "R2", "fall-through queue drained", expQ.size(), 0);
    check(fullOrIr == 0, "R3", "input-ready low after drain", fullOrIr, 0);

    finishRun();
  end
endmodule